// File: doc/BRIEF.md
# I2C Master Transfer Sequencer

This block sequences I2C master transfers one byte-level bus primitive at a time. Software sets a transmit count, a receive count and one or two address bytes. It fills an 8-entry transmit FIFO and then writes a launch command. The engine issues START, the address byte or bytes, the data bytes and, where the mode requires it, STOP. Each primitive goes to a separate bit-level timing engine over a hold-until-done handshake. Received bytes collect in an 8-entry receive FIFO.

There are three command modes. Automatic mode finishes a transfer with STOP. Manual mode finishes without STOP, so that a later command chains on with a repeated START. Sequence mode runs a whole write-then-read exchange from one command. Results go into a sticky status word that is cleared by writing 1. A mask selects which status bits drive the interrupt output.

Both FIFO edges are valid/ready streams. A transmit byte is taken on a cycle where `tx_valid` and `tx_ready` are both high, and `tx_ready` is low only while the transmit FIFO holds 8 bytes. A receive byte leaves on a cycle where `rx_valid` and `rx_ready` are both high, and `rx_valid` is high whenever the receive FIFO is non-empty. When the transmit FIFO is empty or the receive FIFO is full, the engine holds the bus primitive back until space or data appears.

Top module: `i2cm_seq_engine`

## Requirements
- R1: After reset `status`, `busy`, `irq`, `tx_level` and `rx_level` are all zero, `tx_ready` is 1 and `rx_valid` is 0.
- R2: Writing select 0 with bit 3 set starts a command, and bits 1:0 pick the mode (0 manual, 1 automatic, 2 sequence). A write with bit 3 clear, or any command write while `busy` is 1, has no effect.
- R3: Address register 1 (select 3) is always sent first. When its bits 7:3 equal 11110, address register 2 (select 4) follows as a second byte. Otherwise address register 2 is not sent.
- R4: Automatic mode sends START, the address, then the transmit count of bytes (when address bit 0 is 0) or the receive count of reads (when it is 1), and then STOP. Completion of that STOP sets status bit 10.
- R5: Manual mode performs the same phases but sends no STOP. It sets status bit 11 when the last byte completes.
- R6: Sequence mode sends START, the address, and the transmit-count bytes. It then sends a repeated START, address register 1 with bit 0 forced to 1, the receive-count reads, and STOP, and sets bit 10. The receive count (select 2) is re-read during the receive phase, so a rewrite during the run takes effect.
- R7: Each read is acknowledged (`bus_ack`=1) except the last read of the receive count, which is not acknowledged.
- R8: An address NAK sets bit 4 and a data NAK sets bit 5, and either one leads straight to STOP. In manual and automatic modes, completion of that STOP sets bit 9. In sequence mode `busy` stays 1 after the NAK until the STOP is done, and no further status bit is set.
- R9: Arbitration loss on any primitive sets bit 6 and returns the engine to idle without STOP.
- R10: A command with mode 3 is invalid. So is a sequence command with a zero transmit count, a zero receive count, or address bit 0 set. An invalid command sets bit 8 and issues no bus primitive.
- R11: Each FIFO holds 8 bytes and reports its fill on `tx_level`/`rx_level`. The engine stalls while the transmit FIFO is empty or the receive FIFO is full.
- R12: Status bit 13 is 1 while the receive FIFO is non-empty. Status bit 12 is 1 while the engine is busy, the transmit FIFO is not full, and the transmit bytes not yet sent exceed the FIFO level.
- R13: Writing select 5 clears each sticky status bit that is written as 1. `irq` is the OR of `status` ANDed with the mask register (select 6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 cmd, 1 tx count, 2 rx count, 3 addr1, 4 addr2, 5 status clear, 6 mask |
| reg_wdata | input | 16 | Register write data |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Transmit FIFO has room |
| rx_valid | output | 1 | Receive byte available |
| rx_data | output | 8 | Receive FIFO head |
| rx_ready | input | 1 | Consumer takes the receive byte |
| bus_op_valid | output | 1 | Primitive requested; held until done |
| bus_op | output | 2 | 0 START, 1 STOP, 2 write byte, 3 read byte |
| bus_wbyte | output | 8 | Byte to write |
| bus_ack | output | 1 | For reads: 1 acknowledge, 0 no acknowledge |
| bus_done | input | 1 | Primitive complete this cycle |
| bus_rbyte | input | 8 | Byte read |
| bus_nack | input | 1 | Write was not acknowledged |
| bus_lost | input | 1 | Arbitration lost |
| status | output | 16 | Status word |
| busy | output | 1 | Command in progress |
| irq | output | 1 | Masked status summary |
| tx_level | output | 4 | Transmit FIFO fill |
| rx_level | output | 4 | Receive FIFO fill |

## Verification
The engine is driven with an automatic write whose transmit FIFO runs dry partway through, and a manual read whose receive FIFO fills. These show the stall and service behaviour and separate the STOP-ending mode from the chaining mode. A ten-bit sequence command with a receive count rewritten after launch checks the second address byte, the repeated START with the read bit, and the live receive count. Address NAK, data NAK and arbitration loss are injected at chosen primitives to tell the silent sequence-mode STOP apart from the stop-complete report and from the no-STOP abort. Every primitive is compared against a queue of expected primitives.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [1:0] {OP_START = 2'd0, OP_STOP = 2'd1, OP_WRITE = 2'd2, OP_READ = 2'd3} bus_op_e;
  typedef enum logic [1:0] {MODE_MANUAL = 2'd0, MODE_AUTO = 2'd1, MODE_SEQ = 2'd2, MODE_BAD = 2'd3} mode_e;

  localparam int ST_RXREQ  = 13;
  localparam int ST_TXREQ  = 12;
  localparam int ST_MDONE  = 11;
  localparam int ST_ADONE  = 10;
  localparam int ST_STOPC  = 9;
  localparam int ST_BADPAR = 8;
  localparam int ST_ARB    = 6;
  localparam int ST_NDATA  = 5;
  localparam int ST_NADDR  = 4;
  localparam int CMD_GO_BIT = 3;

  localparam logic [2:0] SEL_CMD   = 3'd0;
  localparam logic [2:0] SEL_TXCNT = 3'd1;
  localparam logic [2:0] SEL_RXCNT = 3'd2;
  localparam logic [2:0] SEL_ADR1  = 3'd3;
  localparam logic [2:0] SEL_ADR2  = 3'd4;
  localparam logic [2:0] SEL_STAT  = 3'd5;
  localparam logic [2:0] SEL_MASK  = 3'd6;

  typedef struct packed {
    logic mdone;
    logic adone;
    logic stopc;
    logic arb;
    logic ndata;
    logic naddr;
  } evt_t;
endpackage

// File: rtl/i2cm_fifo.sv
module i2cm_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic          full,
  output logic          empty,
  output logic [LW-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [LW-1:0] cnt;

  assign full  = (cnt == LW'(DEPTH));
  assign empty = (cnt == '0);
  assign level = cnt;
  assign rdata = mem[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push && !full) begin
        mem[wp] <= wdata;
        wp      <= wp + 1'b1;
      end
      if (pop && !empty) rp <= rp + 1'b1;
      cnt <= cnt + LW'(push && !full) - LW'(pop && !empty);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);    // R11
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);   // R11
endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
  import i2cm_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  mode_e         go_mode,
  input  logic [CW-1:0] tx_total,
  input  logic [CW-1:0] rx_total,
  input  logic [7:0]    adr_hi,
  input  logic [7:0]    adr_lo,
  input  logic [7:0]    tx_head,
  input  logic          tx_empty,
  input  logic          rx_full,
  input  logic          bus_done,
  input  logic [7:0]    bus_rbyte,
  input  logic          bus_nack,
  input  logic          bus_lost,
  output logic          busy,
  output logic          tx_pop,
  output logic          rx_push,
  output logic [7:0]    rx_byte,
  output logic          bus_op_valid,
  output logic [1:0]    bus_op,
  output logic [7:0]    bus_wbyte,
  output logic          bus_ack,
  output evt_t          evt,
  output logic [CW-1:0] tx_sent
);
  typedef enum logic [3:0] {S_IDLE, S_START, S_A1, S_A2, S_TX, S_RS, S_RA, S_RX, S_STOP} st_e;
  st_e           st;
  mode_e         mode_q;
  logic          rd_q, err_q, pend;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          ten, tx_left, rx_left, hs;

  assign ten     = (adr_hi[7:3] == 5'b11110);
  assign tx_left = (tx_cnt != tx_total);
  assign rx_left = (rx_cnt < rx_total);
  assign hs      = bus_op_valid && bus_done;
  assign busy    = (st != S_IDLE);
  assign tx_pop  = (st == S_TX) && hs;
  assign rx_push = (st == S_RX) && hs;
  assign rx_byte = bus_rbyte;
  assign tx_sent = tx_cnt;

  always_comb begin
    bus_op_valid = 1'b0;
    bus_op       = OP_START;
    bus_wbyte    = '0;
    bus_ack      = 1'b1;
    case (st)
      S_START, S_RS: bus_op_valid = 1'b1;
      S_A1: begin bus_op_valid = 1'b1; bus_op = OP_WRITE; bus_wbyte = adr_hi; end
      S_A2: begin bus_op_valid = 1'b1; bus_op = OP_WRITE; bus_wbyte = adr_lo; end
      S_RA: begin bus_op_valid = 1'b1; bus_op = OP_WRITE; bus_wbyte = {adr_hi[7:1], 1'b1}; end
      S_TX: begin
        bus_op_valid = pend || (tx_left && !tx_empty);
        bus_op       = OP_WRITE;
        bus_wbyte    = tx_head;
      end
      S_RX: begin
        bus_op_valid = pend || (rx_left && !rx_full);
        bus_op       = OP_READ;
        bus_ack      = (({1'b0, rx_cnt} + 1'b1) < {1'b0, rx_total});
      end
      S_STOP: begin bus_op_valid = 1'b1; bus_op = OP_STOP; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      mode_q <= MODE_MANUAL;
      rd_q   <= 1'b0;
      err_q  <= 1'b0;
      pend   <= 1'b0;
      tx_cnt <= '0;
      rx_cnt <= '0;
      evt    <= '0;
    end else begin
      evt  <= '0;
      pend <= bus_op_valid && !bus_done;
      case (st)
        S_IDLE: if (go) begin
          st     <= S_START;
          mode_q <= go_mode;
          rd_q   <= (go_mode != MODE_SEQ) && adr_hi[0];
          err_q  <= 1'b0;
          tx_cnt <= '0;
          rx_cnt <= '0;
        end
        S_START, S_RS: if (hs) begin
          if (bus_lost) begin evt.arb <= 1'b1; st <= S_IDLE; end
          else st <= (st == S_START) ? S_A1 : S_RA;
        end
        S_A1, S_A2, S_RA: if (hs) begin
          if (bus_lost) begin evt.arb <= 1'b1; st <= S_IDLE; end
          else if (bus_nack) begin evt.naddr <= 1'b1; err_q <= 1'b1; st <= S_STOP; end
          else if (st == S_A1 && ten) st <= S_A2;
          else if (st == S_RA || rd_q) st <= S_RX;
          else st <= S_TX;
        end
        S_TX: begin
          if (hs) begin
            tx_cnt <= tx_cnt + 1'b1;
            if (bus_lost) begin evt.arb <= 1'b1; st <= S_IDLE; end
            else if (bus_nack) begin evt.ndata <= 1'b1; err_q <= 1'b1; st <= S_STOP; end
          end else if (!pend && !tx_left) begin
            if (mode_q == MODE_SEQ) st <= S_RS;
            else if (mode_q == MODE_MANUAL) begin evt.mdone <= 1'b1; st <= S_IDLE; end
            else st <= S_STOP;
          end
        end
        S_RX: begin
          if (hs) begin
            rx_cnt <= rx_cnt + 1'b1;
            if (bus_lost) begin evt.arb <= 1'b1; st <= S_IDLE; end
          end else if (!pend && !rx_left) begin
            if (mode_q == MODE_MANUAL) begin evt.mdone <= 1'b1; st <= S_IDLE; end
            else st <= S_STOP;
          end
        end
        S_STOP: if (hs) begin
          st <= S_IDLE;
          if (bus_lost) evt.arb <= 1'b1;
          else if (!err_q) evt.adone <= 1'b1;
          else if (mode_q != MODE_SEQ) evt.stopc <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_OP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_op_valid && !bus_done) |=> (bus_op_valid && $stable(bus_op)));                      // R11
  AST_RX_ROOM: assert property (@(posedge clk) disable iff (!rst_n) rx_push |-> !rx_full);    // R11
  AST_SEQ_NAK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.naddr && mode_q == MODE_SEQ) |-> busy);                                              // R8
  AST_EVT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(evt));        // R8
  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STOP && hs) |=> !busy);                                                          // R4
endmodule

// File: rtl/i2cm_seq_engine.sv
module i2cm_seq_engine
  import i2cm_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int CNT_W      = 8,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_sel,
  input  logic [15:0]      reg_wdata,
  input  logic             tx_valid,
  input  logic [7:0]       tx_data,
  output logic             tx_ready,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  input  logic             rx_ready,
  output logic             bus_op_valid,
  output logic [1:0]       bus_op,
  output logic [7:0]       bus_wbyte,
  output logic             bus_ack,
  input  logic             bus_done,
  input  logic [7:0]       bus_rbyte,
  input  logic             bus_nack,
  input  logic             bus_lost,
  output logic [15:0]      status,
  output logic             busy,
  output logic             irq,
  output logic [LVL_W-1:0] tx_level,
  output logic [LVL_W-1:0] rx_level
);
  logic [CNT_W-1:0] tx_total, rx_total, tx_sent;
  logic [7:0]       adr_hi, adr_lo, tx_head, rx_byte;
  logic [15:0]      sticky, mask_q, set_v, clr_v;
  logic             tx_full, tx_empty, rx_full, rx_empty, tx_pop, rx_push;
  logic             launch, bad_par, bad_cmd, go, tx_req;
  mode_e            cmd_mode;
  evt_t             evt;

  assign cmd_mode = mode_e'(reg_wdata[1:0]);
  assign launch   = reg_we && (reg_sel == SEL_CMD) && reg_wdata[CMD_GO_BIT] && !busy;
  assign bad_par  = (cmd_mode == MODE_BAD) ||
                    ((cmd_mode == MODE_SEQ) && (tx_total == '0 || rx_total == '0 || adr_hi[0]));
  assign bad_cmd  = launch && bad_par;
  assign go       = launch && !bad_par;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_total <= '0;
      rx_total <= '0;
      adr_hi   <= '0;
      adr_lo   <= '0;
      mask_q   <= '0;
    end else if (reg_we) begin
      case (reg_sel)
        SEL_TXCNT: tx_total <= reg_wdata[CNT_W-1:0];
        SEL_RXCNT: rx_total <= reg_wdata[CNT_W-1:0];
        SEL_ADR1:  adr_hi   <= reg_wdata[7:0];
        SEL_ADR2:  adr_lo   <= reg_wdata[7:0];
        SEL_MASK:  mask_q   <= reg_wdata;
        default: ;
      endcase
    end
  end

  i2cm_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_valid && tx_ready), .wdata(tx_data), .pop(tx_pop),
    .rdata(tx_head), .full(tx_full), .empty(tx_empty), .level(tx_level));

  i2cm_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_byte), .pop(rx_valid && rx_ready),
    .rdata(rx_data), .full(rx_full), .empty(rx_empty), .level(rx_level));

  assign tx_ready = !tx_full;
  assign rx_valid = !rx_empty;

  i2cm_ctrl #(.CW(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .go(go), .go_mode(cmd_mode), .tx_total(tx_total),
    .rx_total(rx_total), .adr_hi(adr_hi), .adr_lo(adr_lo), .tx_head(tx_head),
    .tx_empty(tx_empty), .rx_full(rx_full), .bus_done(bus_done), .bus_rbyte(bus_rbyte),
    .bus_nack(bus_nack), .bus_lost(bus_lost), .busy(busy), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_byte(rx_byte), .bus_op_valid(bus_op_valid), .bus_op(bus_op),
    .bus_wbyte(bus_wbyte), .bus_ack(bus_ack), .evt(evt), .tx_sent(tx_sent));

  always_comb begin
    set_v             = '0;
    set_v[ST_MDONE]   = evt.mdone;
    set_v[ST_ADONE]   = evt.adone;
    set_v[ST_STOPC]   = evt.stopc;
    set_v[ST_BADPAR]  = bad_cmd;
    set_v[ST_ARB]     = evt.arb;
    set_v[ST_NDATA]   = evt.ndata;
    set_v[ST_NADDR]   = evt.naddr;
    clr_v = (reg_we && reg_sel == SEL_STAT) ? reg_wdata : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sticky <= '0;
    else        sticky <= (sticky & ~clr_v) | set_v;
  end

  assign tx_req = busy && !tx_full &&
                  (({1'b0, tx_total} - {1'b0, tx_sent}) > (CNT_W + 1)'(tx_level));

  always_comb begin
    status           = sticky;
    status[ST_RXREQ] = !rx_empty;
    status[ST_TXREQ] = tx_req;
  end

  assign irq = |(status & mask_q);

  AST_BAD_NOT_STARTED: assert property (@(posedge clk) disable iff (!rst_n) bad_cmd |=> !busy);  // R10
  AST_GO_STARTS: assert property (@(posedge clk) disable iff (!rst_n) go |=> busy);              // R2
endmodule

// File: tb/sim_i2cm_seq_engine.sv
module sim_i2cm_seq_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [15:0] reg_wdata = '0;
  logic        tx_valid = 1'b0;
  logic [7:0]  tx_data = '0;
  logic        tx_ready, rx_valid;
  logic [7:0]  rx_data;
  logic        rx_ready = 1'b0;
  logic        bus_op_valid, bus_ack;
  logic [1:0]  bus_op;
  logic [7:0]  bus_wbyte;
  logic        bus_done = 1'b0;
  logic [7:0]  bus_rbyte = '0;
  logic        bus_nack = 1'b0, bus_lost = 1'b0;
  logic [15:0] status;
  logic        busy, irq;
  logic [3:0]  tx_level, rx_level;

  i2cm_seq_engine u0 (.*);

  always #10 clk = ~clk;

  int    n_chk = 0, n_bad = 0;
  int    exp_q[$];
  int    op_idx = 0, rd_ctr = 0, wait_ct = 0;
  int    nack_at = -1, lost_at = -1;
  string cur_req = "R1";

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // behavioural bus responder and primitive comparison
  always @(negedge clk) begin
    bus_done = 1'b0; bus_nack = 1'b0; bus_lost = 1'b0;
    if (!rst_n || !bus_op_valid) wait_ct = 0;
    else if (wait_ct < 2) wait_ct++;
    else begin
      int got;
      wait_ct  = 0;
      bus_done = 1'b1;
      bus_lost = (op_idx == lost_at);
      bus_nack = (bus_op == 2'd2) && (op_idx == nack_at);
      got = {22'd0, bus_op, (bus_op == 2'd2) ? bus_wbyte : (bus_op == 2'd3) ? {7'd0, bus_ack} : 8'd0};
      if (bus_op == 2'd3) begin bus_rbyte = 8'hC0 + 8'(rd_ctr); rd_ctr++; end
      if (exp_q.size() == 0) chk(1'b0, {cur_req, " unexpected primitive"}, got, 32'hFFFF);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(got == e, {cur_req, " primitive"}, got, e);
      end
      op_idx++;
    end
  end

  function automatic int e_op(input int op, input int d); return op * 256 + d; endfunction

  task automatic wr(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk); reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic push_tx(input logic [7:0] b);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1; tx_data = b;
    @(negedge clk); tx_valid = 1'b0;
  endtask

  task automatic pop_rx(output logic [7:0] b);
    @(negedge clk);
    while (!rx_valid) @(negedge clk);
    b = rx_data; rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic begin_test(input string r, input int nk, input int ls);
    cur_req = r; op_idx = 0; rd_ctr = 0; nack_at = nk; lost_at = ls;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    logic [7:0] b;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(status == 16'h0 && !busy && !irq, "R1 status/busy/irq", {status, 7'd0, busy, 7'd0, irq}, 0);
    chk(tx_level == 0 && rx_level == 0 && tx_ready && !rx_valid, "R1 fifo idle",
        {tx_level, rx_level, 6'd0, tx_ready, rx_valid}, 32'h0002);

    // R4/R3/R11/R12: automatic write, 7-bit address, addr2 not sent, transmit FIFO runs dry
    begin_test("R4", -1, -1);
    wr(3'd4, 16'h0077); wr(3'd3, 16'h00A0); wr(3'd1, 16'd10);
    exp_q.push_back(e_op(0, 0)); exp_q.push_back(e_op(2, 8'hA0));
    for (int i = 0; i < 10; i++) exp_q.push_back(e_op(2, 8'h11 * (i + 1) & 8'hFF));
    exp_q.push_back(e_op(1, 0));
    for (int i = 0; i < 3; i++) push_tx(8'(8'h11 * (i + 1)));
    wr(3'd0, 16'h0009);
    @(negedge clk);
    chk(busy, "R2 busy after launch", busy, 1);
    repeat (40) @(negedge clk);
    chk(busy && tx_level == 0, "R11 transmit stall", {busy, tx_level}, {1'b1, 4'd0});
    chk(status[12], "R12 transmit service request", status, 16'h1000);
    for (int i = 3; i < 10; i++) push_tx(8'(8'h11 * (i + 1)));
    wait_idle();
    chk(status == 16'h0400, "R4 automatic done only", status, 16'h0400);
    chk(exp_q.size() == 0, "R3 all primitives seen", exp_q.size(), 0);
    wr(3'd5, 16'h0400);
    @(negedge clk);
    chk(status == 16'h0, "R13 write-one clear", status, 0);

    // R5/R7/R11/R12: manual read of 10 with receive FIFO filling
    begin_test("R5", -1, -1);
    wr(3'd3, 16'h0053); wr(3'd2, 16'd10);
    exp_q.push_back(e_op(0, 0)); exp_q.push_back(e_op(2, 8'h53));
    for (int i = 0; i < 10; i++) exp_q.push_back(e_op(3, (i < 9) ? 1 : 0));
    wr(3'd0, 16'h0008);
    repeat (60) @(negedge clk);
    chk(rx_level == 8 && busy, "R11 receive stall", {busy, rx_level}, {1'b1, 4'd8});
    chk(status[13], "R12 receive service request", status, 16'h2000);
    wr(3'd0, 16'h000B);
    @(negedge clk);
    chk(!status[8], "R2 command while busy ignored", status, 16'h2000);
    for (int i = 0; i < 10; i++) begin
      pop_rx(b);
      chk(b == 8'(8'hC0 + i), "R7 receive byte order", b, 8'(8'hC0 + i));
    end
    wait_idle();
    chk(status == 16'h0800, "R5 manual done, no STOP", status, 16'h0800);
    chk(exp_q.size() == 0, "R7 last read not acknowledged", exp_q.size(), 0);
    wr(3'd6, 16'h0800);
    @(negedge clk);
    chk(irq, "R13 masked interrupt set", irq, 1);
    wr(3'd5, 16'hFFFF);
    @(negedge clk);
    chk(!irq && status == 0, "R13 interrupt cleared", {irq, status}, 0);
    wr(3'd6, 16'h0000);

    // R6/R3: ten-bit sequence, receive count rewritten during the run
    begin_test("R6", -1, -1);
    wr(3'd3, 16'h00F2); wr(3'd4, 16'h0034); wr(3'd1, 16'd2); wr(3'd2, 16'd1);
    push_tx(8'h5A); push_tx(8'h6B);
    exp_q.push_back(e_op(0, 0)); exp_q.push_back(e_op(2, 8'hF2)); exp_q.push_back(e_op(2, 8'h34));
    exp_q.push_back(e_op(2, 8'h5A)); exp_q.push_back(e_op(2, 8'h6B));
    exp_q.push_back(e_op(0, 0)); exp_q.push_back(e_op(2, 8'hF3));
    exp_q.push_back(e_op(3, 1)); exp_q.push_back(e_op(3, 1)); exp_q.push_back(e_op(3, 0));
    exp_q.push_back(e_op(1, 0));
    wr(3'd0, 16'h000A);
    wr(3'd2, 16'd3);
    wait_idle();
    chk(status == 16'h2400, "R6 sequence done", status, 16'h2400);
    for (int i = 0; i < 3; i++) begin
      pop_rx(b);
      chk(b == 8'(8'hC0 + i), "R6 sequence receive data", b, 8'(8'hC0 + i));
    end
    chk(exp_q.size() == 0, "R6 primitives complete", exp_q.size(), 0);
    wr(3'd5, 16'hFFFF);

    // R8: sequence with address NAK, silent STOP
    begin_test("R8", 1, -1);
    wr(3'd3, 16'h00A0); wr(3'd1, 16'd1); wr(3'd2, 16'd2);
    exp_q.push_back(e_op(0, 0)); exp_q.push_back(e_op(2, 8'hA0)); exp_q.push_back(e_op(1, 0));
    wr(3'd0, 16'h000A);
    while (!status[4]) @(negedge clk);
    chk(busy, "R8 busy held after sequence NAK", busy, 1);
    wait_idle();
    chk(status == 16'h0010, "R8 sequence NAK no further event", status, 16'h0010);
    wr(3'd5, 16'hFFFF);

    // R8: automatic write, NAK on last data byte, stop-complete reported
    begin_test("R8", 3, -1);
    wr(3'd1, 16'd2);
    push_tx(8'h01); push_tx(8'h02);
    exp_q.push_back(e_op(0, 0)); exp_q.push_back(e_op(2, 8'hA0));
    exp_q.push_back(e_op(2, 8'h01)); exp_q.push_back(e_op(2, 8'h02)); exp_q.push_back(e_op(1, 0));
    wr(3'd0, 16'h0009);
    wait_idle();
    chk(status == 16'h0220, "R8 data NAK with stop complete", status, 16'h0220);
    wr(3'd5, 16'hFFFF);

    // R9: arbitration lost on address, no STOP
    begin_test("R9", -1, 1);
    exp_q.push_back(e_op(0, 0)); exp_q.push_back(e_op(2, 8'hA0));
    wr(3'd0, 16'h0008);
    wait_idle();
    repeat (10) @(negedge clk);
    chk(status == 16'h0040 && !busy, "R9 arbitration loss", status, 16'h0040);
    chk(exp_q.size() == 0, "R9 no STOP issued", exp_q.size(), 0);
    wr(3'd5, 16'hFFFF);

    // R10: invalid commands
    begin_test("R10", -1, -1);
    wr(3'd0, 16'h000B);
    repeat (10) @(negedge clk);
    chk(status == 16'h0100 && !busy, "R10 mode 3 invalid", status, 16'h0100);
    wr(3'd5, 16'hFFFF);
    wr(3'd2, 16'd0);
    wr(3'd0, 16'h000A);
    repeat (10) @(negedge clk);
    chk(status == 16'h0100 && !busy, "R10 sequence zero receive count", status, 16'h0100);
    wr(3'd5, 16'hFFFF);

    // R2: launch bit clear
    begin_test("R2", -1, -1);
    wr(3'd0, 16'h0001);
    repeat (10) @(negedge clk);
    chk(status == 16'h0 && !busy, "R2 no launch without bit 3", {busy, status}, 0);

    finish_run();
  end
endmodule